// File: doc/BRIEF.md
# Bidirectional FIFO Bus Bridge

This block links a pair of on-chip FIFOs to an external parallel bus that carries 8-bit or 16-bit data. Words that internal logic pushes into the transmit FIFO leave through external read beats. Words that external write beats deliver collect in the receive FIFO until internal logic pops them. The bridge takes one of two roles. As a slave, it answers beats that an external master frames with an active-low select line and a write/read indicator, and it stalls that master with an active-low wait line. As a master, it frames one-cycle beats itself whenever internal logic asks for one.

Two flags help the far side pace its traffic. The read-request flag rises once the transmit FIFO holds enough beats for one full external access, and that access length is configurable. The receive-mark flag rises once the receive FIFO reaches a configurable fill level. In 8-bit mode each FIFO entry carries two beats, and the low byte moves first. Two sticky status bits record beats or internal accesses that had to be thrown away, and a synchronous clear input resets them.

Top module: `fifo_bus_bridge`

## Requirements
- R1: With `cfg_wide` = 1 every beat carries one full 16-bit entry. With `cfg_wide` = 0 every beat carries one byte on bits [7:0], two beats make one entry (the first beat is entry bits [7:0], the second is bits [15:8]), and read beats drive bits [15:8] of `ext_d_out` as zero.
- R2: In slave role (`cfg_master` = 0) a clock edge with `ext_cs_in` = 0, `ext_wr_in` = 1 and `ext_wait_n` = 1 takes `ext_d_in` in as one write beat. Internal pops on `rx_pop` return the received entries in arrival order on `rx_rdata`.
- R3: In slave role, while `ext_cs_in` = 0 and `ext_wr_in` = 0, `ext_d_oe` is 1 and `ext_d_out` shows the next transmit beat. A clock edge with `ext_wait_n` = 1 moves on to the following beat. While `ext_cs_in` = 1, `ext_d_oe` is 0.
- R4: `ext_rd_req` is 1 exactly when the number of beats held in the transmit FIFO is at least `cfg_xfer_beats` (1 to 16). That number is the entry count in 16-bit mode. In 8-bit mode it is twice the entry count, minus one when the low byte of the head entry has already been sent.
- R5: `ext_rx_mark` is 1 exactly when the receive FIFO holds at least `cfg_rx_mark` entries (1 to 32).
- R6: In slave role `ext_wait_n` is 0 during a read beat while the transmit FIFO is empty, and during a write beat that would need a new entry while the receive FIFO is full (32 entries). The stalled beat completes, with nothing lost, once space or data appears. In every other case `ext_wait_n` is 1, and it is always 1 in master role.
- R7: In master role, `mst_start` = 1 with `mst_write` = 1 at an edge, with transmit data present, makes the next cycle a write beat. During that beat `ext_cs_out` = 0, `ext_wr_out` = 1, `ext_rd_n` = 1, `ext_d_oe` = 1 and `ext_d_out` carries the next transmit beat. The beat lasts exactly one cycle.
- R8: In master role, `mst_start` = 1 with `mst_write` = 0 at an edge makes the next cycle a read beat. During that beat `ext_cs_out` = 0, `ext_wr_out` = 0, `ext_rd_n` = 0 and `ext_d_oe` = 0. `ext_d_in` is stored into the receive path at the edge that ends the beat.
- R9: In slave role `ext_cs_oe` = 0, `ext_wr_oe` = 0 and `ext_rd_n` = 1. In master role `ext_cs_oe` = 1 and `ext_wr_oe` = 1, and `ext_cs_out` = 1 between beats. `mst_start` has no effect in slave role.
- R10: `sts_ovf` becomes 1 after a `tx_push` while `tx_full` = 1, or after a master read beat that finds the receive FIFO full. `sts_unf` becomes 1 after an `rx_pop` while `rx_empty` = 1, or after a master write start while the transmit FIFO is empty, and in that case no beat is issued. Both bits stay set until a cycle with `stat_clr` = 1.
- R11: After reset both FIFOs are empty, `ext_rd_req`, `ext_rx_mark`, `sts_ovf`, `sts_unf` and `ext_d_oe` are 0, and `ext_wait_n`, `ext_rd_n` and `ext_cs_out` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_master | input | 1 | 1 selects master role, 0 selects slave role |
| cfg_wide | input | 1 | 1 selects 16-bit beats, 0 selects 8-bit beats |
| cfg_xfer_beats | input | 5 | Beats in one external access, 1 to 16 |
| cfg_rx_mark | input | 6 | Receive fill level for the mark flag, 1 to 32 |
| stat_clr | input | 1 | Clears both sticky status bits |
| tx_push | input | 1 | Pushes `tx_wdata` into the transmit FIFO |
| tx_wdata | input | 16 | Entry to push |
| tx_full | output | 1 | Transmit FIFO holds 32 entries |
| rx_pop | input | 1 | Removes the head entry of the receive FIFO |
| rx_rdata | output | 16 | Head entry of the receive FIFO |
| rx_empty | output | 1 | Receive FIFO holds no entry |
| mst_start | input | 1 | Requests one master beat |
| mst_write | input | 1 | Direction of the requested beat, 1 is write |
| ext_d_in | input | 16 | External data bus, sampled value |
| ext_d_out | output | 16 | External data bus, driven value |
| ext_d_oe | output | 1 | Enable for driving `ext_d_out` |
| ext_wr_in | input | 1 | Write/read indicator, sampled in slave role |
| ext_wr_out | output | 1 | Write/read indicator, driven in master role |
| ext_wr_oe | output | 1 | Enable for driving `ext_wr_out` |
| ext_cs_in | input | 1 | Active-low select/strobe, sampled in slave role |
| ext_cs_out | output | 1 | Active-low select/strobe, driven in master role |
| ext_cs_oe | output | 1 | Enable for driving `ext_cs_out` |
| ext_rd_n | output | 1 | Active-low read enable, master role only |
| ext_rd_req | output | 1 | Transmit FIFO holds one full access |
| ext_rx_mark | output | 1 | Receive FIFO reached the mark |
| ext_wait_n | output | 1 | Active-low stall for the external master |
| sts_ovf | output | 1 | Sticky overflow |
| sts_unf | output | 1 | Sticky underflow |

## Verification
The slave outputs `ext_wait_n`, `ext_d_oe` and `ext_d_out` respond in the same cycle as the select and indicator inputs. The bench therefore samples them a short delay after it drives those inputs, half a cycle before the edge that completes the beat. The FIFO-derived flags (`ext_rd_req`, `ext_rx_mark`, `rx_empty`) and the sticky bits change one edge after the push, pop or beat, and they are checked at the falling edge that follows. A master beat appears one edge after `mst_start`, stays for exactly that cycle, and is checked in both that cycle and the next. Each received entry is compared in order by a monitor, which pops the entry at the falling edge when it becomes visible.

// File: rtl/fbb_pkg.sv
package fbb_pkg;
   // Beat direction as seen from the external bus.
   typedef enum logic {
      BEAT_READ  = 1'b0,
      BEAT_WRITE = 1'b1
   } beat_dir_e;
endpackage

// File: rtl/fbb_fifo.sv
module fbb_fifo #(
   parameter int DW    = 16,
   parameter int DEPTH = 32,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] wdata,
   input  logic          pop,
   output logic [DW-1:0] head,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty
);
   localparam bit POW2 = (DEPTH == (1 << AW));

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_nx, rd_nx;
   logic          push_ok, pop_ok;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign head    = mem[rd_ptr];

   generate
      if (POW2) begin : g_wrap_natural
         assign wr_nx = wr_ptr + 1'b1;
         assign rd_nx = rd_ptr + 1'b1;
      end else begin : g_wrap_compare
         assign wr_nx = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nx = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_nx;
         if (pop_ok)  rd_ptr <= rd_nx;
         case ({push_ok, pop_ok})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/fbb_rx_pack.sv
module fbb_rx_pack #(
   parameter int DW = 16,
   localparam int HW = DW / 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wide,
   input  logic          beat,
   input  logic [DW-1:0] din,
   input  logic          room,
   output logic          can_take,
   output logic          push,
   output logic [DW-1:0] pdata
);
   logic          phase;
   logic [HW-1:0] lo_q;
   logic          taken;

   // First byte of a pair only needs the holding register.
   assign can_take = wide ? room : (!phase || room);
   assign taken    = beat && can_take;
   assign push     = taken && (wide || phase);
   assign pdata    = wide ? din : {din[HW-1:0], lo_q};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= 1'b0;
         lo_q  <= '0;
      end else if (taken && !wide) begin
         if (!phase) lo_q <= din[HW-1:0];
         phase <= !phase;
      end
   end
endmodule

// File: rtl/fbb_tx_unpack.sv
module fbb_tx_unpack #(
   parameter int DW    = 16,
   parameter int DEPTH = 32,
   localparam int HW   = DW / 2,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wide,
   input  logic [DW-1:0] head,
   input  logic [CW-1:0] count,
   input  logic          take,
   output logic          can_give,
   output logic [DW-1:0] bdata,
   output logic          pop,
   output logic [CW:0]   beats
);
   logic phase;

   assign can_give = (count != '0);
   assign bdata    = wide ? head
                          : {HW'(0), (phase ? head[DW-1:HW] : head[HW-1:0])};
   assign pop      = take && can_give && (wide || phase);
   assign beats    = wide ? {1'b0, count}
                          : ({count, 1'b0} - (CW+1)'(phase));

   always_ff @(posedge clk) begin
      if (!rst_n)                          phase <= 1'b0;
      else if (take && can_give && !wide)  phase <= !phase;
   end
endmodule

// File: rtl/fifo_bus_bridge.sv
module fifo_bus_bridge
   import fbb_pkg::*;
#(
   parameter int  DATA_W   = 16,
   parameter int  DEPTH    = 32,
   parameter int  BEAT_MAX = 16,
   localparam int CW       = $clog2(DEPTH + 1),
   localparam int XW       = $clog2(BEAT_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_master,
   input  logic              cfg_wide,
   input  logic [XW-1:0]     cfg_xfer_beats,
   input  logic [CW-1:0]     cfg_rx_mark,
   input  logic              stat_clr,
   input  logic              tx_push,
   input  logic [DATA_W-1:0] tx_wdata,
   output logic              tx_full,
   input  logic              rx_pop,
   output logic [DATA_W-1:0] rx_rdata,
   output logic              rx_empty,
   input  logic              mst_start,
   input  logic              mst_write,
   input  logic [DATA_W-1:0] ext_d_in,
   output logic [DATA_W-1:0] ext_d_out,
   output logic              ext_d_oe,
   input  logic              ext_wr_in,
   output logic              ext_wr_out,
   output logic              ext_wr_oe,
   input  logic              ext_cs_in,
   output logic              ext_cs_out,
   output logic              ext_cs_oe,
   output logic              ext_rd_n,
   output logic              ext_rd_req,
   output logic              ext_rx_mark,
   output logic              ext_wait_n,
   output logic              sts_ovf,
   output logic              sts_unf
);
   // Elaboration-time parameter checks.
   if (DATA_W < 2 || (DATA_W % 2) != 0) begin : g_bad_width
      $error("DATA_W must be even and at least 2");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be at least 2");
   end
   if (BEAT_MAX < 1 || BEAT_MAX > 2 * DEPTH) begin : g_bad_beats
      $error("BEAT_MAX must lie in 1 .. 2*DEPTH");
   end

   // Slave-side decode.
   logic slv_sel, slv_wr, slv_rd;
   assign slv_sel = !cfg_master && !ext_cs_in;
   assign slv_wr  = slv_sel && (beat_dir_e'(ext_wr_in) == BEAT_WRITE);
   assign slv_rd  = slv_sel && (beat_dir_e'(ext_wr_in) == BEAT_READ);

   // Master beat register.
   logic              m_act, m_wr;
   logic [DATA_W-1:0] m_data;
   logic              mst_go, mst_tx_ok, m_rd_beat;

   // Transmit path.
   logic              tx_empty_unused;
   logic [DATA_W-1:0] tx_head;
   logic [CW-1:0]     tx_cnt;
   logic              tx_can, tx_pop, tx_take;
   logic [DATA_W-1:0] tx_bdata;
   logic [CW:0]       tx_beats;

   // Receive path.
   logic              rx_full, rx_can, rx_push;
   logic [DATA_W-1:0] rx_pdata;
   logic [CW-1:0]     rx_cnt;

   assign mst_go    = cfg_master && mst_start;
   assign mst_tx_ok = mst_go && mst_write && tx_can;
   assign m_rd_beat = m_act && !m_wr;
   assign tx_take   = (slv_rd && tx_can) || mst_tx_ok;

   fbb_fifo #(.DW(DATA_W), .DEPTH(DEPTH)) u_tx_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (tx_push),
      .wdata (tx_wdata),
      .pop   (tx_pop),
      .head  (tx_head),
      .count (tx_cnt),
      .full  (tx_full),
      .empty (tx_empty_unused)
   );

   fbb_tx_unpack #(.DW(DATA_W), .DEPTH(DEPTH)) u_tx_unpack (
      .clk      (clk),
      .rst_n    (rst_n),
      .wide     (cfg_wide),
      .head     (tx_head),
      .count    (tx_cnt),
      .take     (tx_take),
      .can_give (tx_can),
      .bdata    (tx_bdata),
      .pop      (tx_pop),
      .beats    (tx_beats)
   );

   fbb_rx_pack #(.DW(DATA_W)) u_rx_pack (
      .clk      (clk),
      .rst_n    (rst_n),
      .wide     (cfg_wide),
      .beat     (slv_wr || m_rd_beat),
      .din      (ext_d_in),
      .room     (!rx_full),
      .can_take (rx_can),
      .push     (rx_push),
      .pdata    (rx_pdata)
   );

   fbb_fifo #(.DW(DATA_W), .DEPTH(DEPTH)) u_rx_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (rx_push),
      .wdata (rx_pdata),
      .pop   (rx_pop),
      .head  (rx_rdata),
      .count (rx_cnt),
      .full  (rx_full),
      .empty (rx_empty)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         m_act  <= 1'b0;
         m_wr   <= 1'b0;
         m_data <= '0;
      end else begin
         m_act <= mst_tx_ok || (mst_go && !mst_write);
         m_wr  <= mst_write;
         if (mst_tx_ok) m_data <= tx_bdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sts_ovf <= 1'b0;
         sts_unf <= 1'b0;
      end else begin
         sts_ovf <= (sts_ovf && !stat_clr) || (tx_push && tx_full) || (m_rd_beat && !rx_can);
         sts_unf <= (sts_unf && !stat_clr) || (rx_pop && rx_empty) ||
                    (mst_go && mst_write && !tx_can);
      end
   end

   assign ext_wait_n  = !((slv_wr && !rx_can) || (slv_rd && !tx_can));
   assign ext_cs_oe   = cfg_master;
   assign ext_wr_oe   = cfg_master;
   assign ext_cs_out  = !m_act;
   assign ext_wr_out  = m_act && m_wr;
   assign ext_rd_n    = !m_rd_beat;
   assign ext_d_oe    = (m_act && m_wr) || slv_rd;
   assign ext_d_out   = m_act ? m_data : tx_bdata;
   assign ext_rd_req  = (tx_beats >= (CW+1)'(cfg_xfer_beats));
   assign ext_rx_mark = (rx_cnt >= cfg_rx_mark);
endmodule

// File: rtl/fbb_checker.sv
module fbb_checker (
   input logic clk,
   input logic rst_n,
   input logic cfg_master,
   input logic mst_start,
   input logic stat_clr,
   input logic ext_cs_in,
   input logic ext_cs_out,
   input logic ext_d_oe,
   input logic ext_rd_n,
   input logic ext_wait_n,
   input logic ext_rx_mark,
   input logic rx_empty,
   input logic sts_ovf,
   input logic sts_unf
);
   AST_RDN_SLAVE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_master |-> ext_rd_n); // R9
   AST_WAIT_MASTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_master |-> ext_wait_n); // R6
   AST_BEAT_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_cs_out |-> $past(mst_start)); // R7
   AST_MARK_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      rx_empty |-> !ext_rx_mark); // R5
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sts_ovf) && !$past(stat_clr)) |-> sts_ovf); // R10
   AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sts_unf) && !$past(stat_clr)) |-> sts_unf); // R10
   AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_master && ext_cs_in) |-> !ext_d_oe); // R3
endmodule

bind fifo_bus_bridge fbb_checker u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_master  (cfg_master),
   .mst_start   (mst_start),
   .stat_clr    (stat_clr),
   .ext_cs_in   (ext_cs_in),
   .ext_cs_out  (ext_cs_out),
   .ext_d_oe    (ext_d_oe),
   .ext_rd_n    (ext_rd_n),
   .ext_wait_n  (ext_wait_n),
   .ext_rx_mark (ext_rx_mark),
   .rx_empty    (rx_empty),
   .sts_ovf     (sts_ovf),
   .sts_unf     (sts_unf)
);

// File: tb/fifo_bus_bridge_tb.sv
`timescale 1ns/100ps
module fifo_bus_bridge_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_master = 1'b0, cfg_wide = 1'b1, stat_clr = 1'b0;
   logic [4:0]  cfg_xfer_beats = 5'd2;
   logic [5:0]  cfg_rx_mark = 6'd3;
   logic        tx_push = 1'b0, rx_pop = 1'b0, mst_start = 1'b0, mst_write = 1'b0;
   logic [15:0] tx_wdata = '0, ext_d_in = '0;
   logic        ext_wr_in = 1'b0, ext_cs_in = 1'b1;
   logic        tx_full, rx_empty, ext_d_oe, ext_wr_out, ext_wr_oe, ext_cs_out, ext_cs_oe;
   logic        ext_rd_n, ext_rd_req, ext_rx_mark, ext_wait_n, sts_ovf, sts_unf;
   logic [15:0] rx_rdata, ext_d_out;

   int  n_chk = 0, n_fail = 0;
   bit  mon_en = 1'b0, done = 1'b0;
   logic [15:0] exp_q[$];

   always #2.5 clk = ~clk;

   fifo_bus_bridge u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_wide(cfg_wide),
      .cfg_xfer_beats(cfg_xfer_beats), .cfg_rx_mark(cfg_rx_mark), .stat_clr(stat_clr),
      .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_full(tx_full),
      .rx_pop(rx_pop), .rx_rdata(rx_rdata), .rx_empty(rx_empty),
      .mst_start(mst_start), .mst_write(mst_write),
      .ext_d_in(ext_d_in), .ext_d_out(ext_d_out), .ext_d_oe(ext_d_oe),
      .ext_wr_in(ext_wr_in), .ext_wr_out(ext_wr_out), .ext_wr_oe(ext_wr_oe),
      .ext_cs_in(ext_cs_in), .ext_cs_out(ext_cs_out), .ext_cs_oe(ext_cs_oe),
      .ext_rd_n(ext_rd_n), .ext_rd_req(ext_rd_req), .ext_rx_mark(ext_rx_mark),
      .ext_wait_n(ext_wait_n), .sts_ovf(sts_ovf), .sts_unf(sts_unf)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Monitor: compares each received entry against the scoreboard (R2).
   initial begin
      forever begin
         @(negedge clk);
         rx_pop = 1'b0;
         if (mon_en && !rx_empty) begin
            if (exp_q.size() == 0) chk("R2 unexpected rx entry", {16'h0, rx_rdata}, 32'hFFFF_FFFF);
            else                   chk("R2 rx entry order/data", {16'h0, rx_rdata}, {16'h0, exp_q.pop_front()});
            rx_pop = 1'b1;
         end
      end
   end

   // All tasks start just after a falling edge and return on one.
   task automatic beat(input logic wr, input logic [15:0] v, output logic [15:0] rd);
      ext_cs_in = 1'b0; ext_wr_in = wr; ext_d_in = v;
      #1;
      while (!ext_wait_n) begin @(negedge clk); #1; end
      rd = ext_d_out;
      @(negedge clk);
      ext_cs_in = 1'b1;
   endtask

   task automatic s_write16(input logic [15:0] v);
      logic [15:0] dummy;
      exp_q.push_back(v);
      beat(1'b1, v, dummy);
   endtask

   task automatic s_write8pair(input logic [15:0] v);
      logic [15:0] dummy;
      exp_q.push_back(v);
      beat(1'b1, {8'h00, v[7:0]}, dummy);
      beat(1'b1, {8'h00, v[15:8]}, dummy);
   endtask

   task automatic s_read(input string tag, input logic [15:0] exp);
      logic [15:0] got;
      ext_cs_in = 1'b0; ext_wr_in = 1'b0; #1;
      chk({tag, " oe"}, {31'h0, ext_d_oe}, 32'h1);
      beat(1'b0, 16'h0, got);
      chk(tag, {16'h0, got}, {16'h0, exp});
   endtask

   task automatic tpush(input logic [15:0] v);
      tx_push = 1'b1; tx_wdata = v;
      @(negedge clk);
      tx_push = 1'b0;
   endtask

   task automatic drain();
      mon_en = 1'b1;
      while (exp_q.size() != 0) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      // R11 reset state, R9 slave direction
      chk("R11 rd_req", {31'h0, ext_rd_req}, 0);
      chk("R11 rx_mark", {31'h0, ext_rx_mark}, 0);
      chk("R11 rx_empty", {31'h0, rx_empty}, 1);
      chk("R11 wait_n", {31'h0, ext_wait_n}, 1);
      chk("R11 sticky", {30'h0, sts_ovf, sts_unf}, 0);
      chk("R11 cs_out/d_oe", {30'h0, ext_cs_out, ext_d_oe}, 32'h2);
      chk("R9 slave oe and rd_n", {29'h0, ext_cs_oe, ext_wr_oe, ext_rd_n}, 32'h1);

      // R2 and R5: wide slave writes, mark at 3
      s_write16(16'hA1B2); chk("R5 mark after 1", {31'h0, ext_rx_mark}, 0);
      s_write16(16'h0C0D); chk("R5 mark after 2", {31'h0, ext_rx_mark}, 0);
      s_write16(16'h7E57); chk("R5 mark after 3", {31'h0, ext_rx_mark}, 1);
      drain();
      chk("R5 mark after drain", {31'h0, ext_rx_mark}, 0);

      // R1: narrow writes pack low byte first
      cfg_wide = 1'b0;
      s_write8pair(16'h1234);
      s_write8pair(16'h5678);
      drain();

      // R3 and R4: wide slave reads, access size 2
      cfg_wide = 1'b1; cfg_xfer_beats = 5'd2;
      tpush(16'h1111); chk("R4 wide 1 beat", {31'h0, ext_rd_req}, 0);
      tpush(16'h2222); chk("R4 wide 2 beats", {31'h0, ext_rd_req}, 1);
      s_read("R3 wide read 1", 16'h1111);
      chk("R4 wide back to 1 beat", {31'h0, ext_rd_req}, 0);
      s_read("R3 wide read 2", 16'h2222);
      #1 chk("R3 idle no drive", {31'h0, ext_d_oe}, 0);

      // R1 and R4: narrow reads, access size 3
      cfg_wide = 1'b0; cfg_xfer_beats = 5'd3;
      tpush(16'hBEEF); chk("R4 narrow 2 beats", {31'h0, ext_rd_req}, 0);
      tpush(16'hCAFE); chk("R4 narrow 4 beats", {31'h0, ext_rd_req}, 1);
      s_read("R1 narrow low byte", 16'h00EF);
      chk("R4 narrow 3 beats", {31'h0, ext_rd_req}, 1);
      s_read("R1 narrow high byte", 16'h00BE);
      chk("R4 narrow 2 left", {31'h0, ext_rd_req}, 0);
      s_read("R1 narrow byte 3", 16'h00FE);
      s_read("R1 narrow byte 4", 16'h00CA);

      // R6: wait on empty TX read, on full RX write
      cfg_wide = 1'b1;
      ext_cs_in = 1'b0; ext_wr_in = 1'b0; #1;
      chk("R6 wait on empty tx", {31'h0, ext_wait_n}, 0);
      @(negedge clk); ext_cs_in = 1'b1; #1;
      chk("R6 wait released", {31'h0, ext_wait_n}, 1);
      @(negedge clk);
      mon_en = 1'b0; cfg_rx_mark = 6'd32;
      for (int i = 0; i < 32; i++) s_write16(16'h0100 + 16'(i));
      chk("R5 mark at 32", {31'h0, ext_rx_mark}, 1);
      ext_cs_in = 1'b0; ext_wr_in = 1'b1; ext_d_in = 16'hD00D; #1;
      chk("R6 wait on full rx", {31'h0, ext_wait_n}, 0);
      repeat (3) @(negedge clk);
      #1 chk("R6 wait held", {31'h0, ext_wait_n}, 0);
      exp_q.push_back(16'hD00D);
      mon_en = 1'b1;
      while (!ext_wait_n) begin @(negedge clk); #1; end
      @(negedge clk); ext_cs_in = 1'b1;
      drain();
      cfg_rx_mark = 6'd3;

      // R9 and R7: master role, write beat
      cfg_master = 1'b1; ext_cs_in = 1'b0; ext_wr_in = 1'b1; #1;
      chk("R9 master oe", {30'h0, ext_cs_oe, ext_wr_oe}, 32'h3);
      chk("R9 master idle cs", {31'h0, ext_cs_out}, 1);
      chk("R6 wait high in master", {31'h0, ext_wait_n}, 1);
      @(negedge clk); ext_cs_in = 1'b1;
      tpush(16'h5A5A);
      mst_start = 1'b1; mst_write = 1'b1;
      @(negedge clk); mst_start = 1'b0; #1;
      chk("R7 beat strobes", {28'h0, ext_cs_out, ext_wr_out, ext_rd_n, ext_d_oe}, 32'h7);
      chk("R7 beat data", {16'h0, ext_d_out}, 32'h5A5A);
      @(negedge clk); #1;
      chk("R7 one cycle", {30'h0, ext_cs_out, ext_d_oe}, 32'h2);

      // R8: master read beat
      @(negedge clk);
      mst_start = 1'b1; mst_write = 1'b0; ext_d_in = 16'h3C3C;
      exp_q.push_back(16'h3C3C);
      @(negedge clk); mst_start = 1'b0; #1;
      chk("R8 beat strobes", {28'h0, ext_cs_out, ext_wr_out, ext_rd_n, ext_d_oe}, 32'h0);
      @(negedge clk); #1;
      chk("R8 one cycle", {30'h0, ext_cs_out, ext_rd_n}, 32'h3);
      drain();

      // R10: underflow on master write with empty TX
      mst_start = 1'b1; mst_write = 1'b1;
      @(negedge clk); mst_start = 1'b0; #1;
      chk("R10 no beat on empty tx", {31'h0, ext_cs_out}, 1);
      chk("R10 unf set", {31'h0, sts_unf}, 1);
      @(negedge clk); stat_clr = 1'b1;
      @(negedge clk); stat_clr = 1'b0;
      chk("R10 unf cleared", {31'h0, sts_unf}, 0);

      // R10: overflow on push into full TX; R9 start ignored in slave role
      cfg_master = 1'b0;
      for (int i = 0; i < 32; i++) tpush(16'h2000 + 16'(i));
      chk("R10 tx full", {30'h0, tx_full, sts_ovf}, 32'h2);
      mst_start = 1'b1; mst_write = 1'b1;
      @(negedge clk); mst_start = 1'b0; #1;
      chk("R9 start ignored in slave", {30'h0, ext_cs_out, sts_unf}, 32'h2);
      tpush(16'hFFFF);
      chk("R10 ovf set", {31'h0, sts_ovf}, 1);
      stat_clr = 1'b1; @(negedge clk); stat_clr = 1'b0;
      chk("R10 ovf cleared", {31'h0, sts_ovf}, 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule